// File: doc/BRIEF.md
# Two-Thread Shared-Cluster Issue Selector

This block picks, every cycle, the instructions that leave two hardware-thread ready windows for a shared execution cluster. Each thread offers a small window of entries. Each entry carries a ready bit and an operation-class bit (arithmetic or memory). Each thread also has one stall bit. The cluster has several arithmetic units and exactly one load/store unit, and up to `ISSUE_W` instructions leave per cycle. Instructions from both threads can leave in the same cycle. When one thread is stalled, its unused slots go to the other thread's ready work.

The selector is purely combinational from the window inputs to the grants. One priority bit and two issued-instruction counters are the only state. The grants go back to each thread's window as per-entry masks. A packed slot list tells the execution cluster, for each issue slot, which thread and entry it carries and which unit executes it. A policy input chooses the order in which the threads are served:
- an equal-progress order that alternates between the threads;
- a throughput order that serves the thread with more ready work first.

Top module: `smt_issue_sel`

## Requirements
- R1: At most `ISSUE_W` (default 4) entries are granted per cycle across both threads, and grants may go to both threads in the same cycle.
- R2: A thread whose stall bit is 1 receives no grant. When fewer than `ISSUE_W` slots are used and arithmetic units remain free, no ready arithmetic entry of a non-stalled thread is left ungranted.
- R3: At most one memory-class entry (class bit 1) is granted per cycle. A memory entry that loses the load/store unit is not granted, while younger arithmetic entries of the same thread may still be granted. A memory entry that stays ready is granted in a later cycle once the unit is free to it.
- R4: Within a thread, entries are considered from index 0 upward. A younger entry is never granted while an older ready entry that could have used the same resource is skipped.
- R5: With policy 1 (equal progress), the thread named by a one-bit priority pointer is served first. The pointer is 0 after reset and flips after every cycle in which both threads had a ready, non-stalled entry; otherwise it holds.
- R6: With policy 0 (throughput), the thread with more ready non-stalled entries is served first. On a tie the priority pointer decides.
- R7: Slots are filled from slot 0 upward with no gaps: first the served-first thread's grants by ascending index, then the other thread's. The unit code is `N_ALU` (4 by default) for the load/store unit. Arithmetic entries get unit codes 0, 1, 2 … in slot order.
- R8: Each thread has a `CNT_W`-bit issued counter that is 0 after reset (including an asynchronous reset in mid-run) and adds that thread's grant count at every clock edge.

Stall bits are `stall_i[t]`. Window entry `i` of thread `t` is bit `i` of `rdy_i[t]` and `mem_i[t]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 1 | 0 = throughput order, 1 = equal-progress order |
| stall_i | input | 2 | Per-thread stall bit |
| rdy_i | input | 2 x WIN | Per-thread ready bit for each window entry |
| mem_i | input | 2 x WIN | Per-thread class bit for each entry, 1 = memory |
| grant_o | output | 2 x WIN | Per-thread grant mask for each window entry |
| slot_vld_o | output | ISSUE_W | Slot carries an instruction |
| slot_thr_o | output | ISSUE_W | Thread of each slot |
| slot_idx_o | output | ISSUE_W x IDX_W | Window index of each slot |
| slot_unit_o | output | ISSUE_W x UNIT_W | Unit code of each slot, N_ALU = load/store |
| issued_cnt_o | output | 2 x CNT_W | Per-thread issued-instruction counter |

## Verification
The bench builds the block with its defaults: a four-entry window per thread, four issue slots and four arithmetic units. Four-bit masks are therefore enough to fill every slot from one thread, to split the width across both threads, and to make two memory entries contend for the single load/store unit in one cycle. Short sequences of cycles, one vector per cycle, step the priority pointer through known states. This lets the bench check both serving orders, the tie rule and the pointer restart after a reset in mid-run against hand-derived grants and slot maps.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;
  localparam int NTHR = 2;

  typedef enum logic {
    POL_THRU  = 1'b0,
    POL_EQUAL = 1'b1
  } policy_e;
endpackage

// File: rtl/smt_first_sel.sv
// Decides which thread is served first in the current cycle.
module smt_first_sel #(
  parameter int WIN = 4
) (
  input  logic                          policy_eq,
  input  logic                          prio,
  input  logic [smt_issue_pkg::NTHR-1:0][WIN-1:0] elig,
  output logic                          first
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] n0, n1;

  always_comb begin
    n0 = CW'($countones(elig[0]));
    n1 = CW'($countones(elig[1]));
    if (policy_eq)     first = prio;
    else if (n0 > n1)  first = 1'b0;
    else if (n1 > n0)  first = 1'b1;
    else               first = prio;
  end
endmodule

// File: rtl/smt_thread_pick.sv
// Oldest-first granting for one thread against the remaining slot,
// arithmetic-unit and load/store budgets.
module smt_thread_pick #(
  parameter int WIN     = 4,
  parameter int ISSUE_W = 4,
  parameter int N_ALU   = 4,
  localparam int SCW    = $clog2(ISSUE_W + 1),
  localparam int ACW    = $clog2(N_ALU + 1)
) (
  input  logic [WIN-1:0] rdy,
  input  logic [WIN-1:0] mem,
  input  logic [SCW-1:0] slots_in,
  input  logic [ACW-1:0] alus_in,
  input  logic           lsu_free_in,
  output logic [WIN-1:0] grant,
  output logic [SCW-1:0] slots_out,
  output logic [ACW-1:0] alus_out,
  output logic           lsu_free_out
);
  always_comb begin
    logic [SCW-1:0] s;
    logic [ACW-1:0] a;
    logic           l;
    s     = slots_in;
    a     = alus_in;
    l     = lsu_free_in;
    grant = '0;
    for (int i = 0; i < WIN; i++) begin
      if (rdy[i] && (s < SCW'(ISSUE_W))) begin
        if (mem[i]) begin
          if (l) begin
            grant[i] = 1'b1;
            l        = 1'b0;
            s        = s + 1'b1;
          end
        end else if (a < ACW'(N_ALU)) begin
          grant[i] = 1'b1;
          a        = a + 1'b1;
          s        = s + 1'b1;
        end
      end
    end
    slots_out    = s;
    alus_out     = a;
    lsu_free_out = l;
  end
endmodule

// File: rtl/smt_slot_pack.sv
// Packs the two stage grant masks into the issue slot list.
module smt_slot_pack #(
  parameter int WIN     = 4,
  parameter int ISSUE_W = 4,
  parameter int N_ALU   = 4,
  localparam int IDX_W  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int UNIT_W = $clog2(N_ALU + 1)
) (
  input  logic [smt_issue_pkg::NTHR-1:0][WIN-1:0] st_grant,
  input  logic [smt_issue_pkg::NTHR-1:0][WIN-1:0] st_mem,
  input  logic                                    first,
  output logic [ISSUE_W-1:0]                      slot_vld,
  output logic [ISSUE_W-1:0]                      slot_thr,
  output logic [ISSUE_W-1:0][IDX_W-1:0]           slot_idx,
  output logic [ISSUE_W-1:0][UNIT_W-1:0]          slot_unit
);
  always_comb begin
    int n;
    int a;
    n         = 0;
    a         = 0;
    slot_vld  = '0;
    slot_thr  = '0;
    slot_idx  = '0;
    slot_unit = '0;
    for (int st = 0; st < smt_issue_pkg::NTHR; st++) begin
      for (int i = 0; i < WIN; i++) begin
        if (st_grant[st][i] && (n < ISSUE_W)) begin
          slot_vld[n] = 1'b1;
          slot_thr[n] = (st == 0) ? first : ~first;
          slot_idx[n] = IDX_W'(i);
          if (st_mem[st][i]) begin
            slot_unit[n] = UNIT_W'(N_ALU);
          end else begin
            slot_unit[n] = UNIT_W'(a);
            a = a + 1;
          end
          n = n + 1;
        end
      end
    end
  end
endmodule

// File: rtl/smt_issue_sel.sv
module smt_issue_sel #(
  parameter int WIN     = 4,
  parameter int ISSUE_W = 4,
  parameter int N_ALU   = 4,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int UNIT_W = $clog2(N_ALU + 1)
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    policy_i,
  input  logic [smt_issue_pkg::NTHR-1:0]          stall_i,
  input  logic [smt_issue_pkg::NTHR-1:0][WIN-1:0] rdy_i,
  input  logic [smt_issue_pkg::NTHR-1:0][WIN-1:0] mem_i,
  output logic [smt_issue_pkg::NTHR-1:0][WIN-1:0] grant_o,
  output logic [ISSUE_W-1:0]                      slot_vld_o,
  output logic [ISSUE_W-1:0]                      slot_thr_o,
  output logic [ISSUE_W-1:0][IDX_W-1:0]           slot_idx_o,
  output logic [ISSUE_W-1:0][UNIT_W-1:0]          slot_unit_o,
  output logic [smt_issue_pkg::NTHR-1:0][CNT_W-1:0] issued_cnt_o
);
  import smt_issue_pkg::*;

  localparam int SCW = $clog2(ISSUE_W + 1);
  localparam int ACW = $clog2(N_ALU + 1);

  logic [NTHR-1:0][WIN-1:0] elig;
  logic [NTHR-1:0]          any_elig;
  logic                     both_elig;
  logic                     first;
  logic                     prio_q, prio_d, prio_en;

  logic [NTHR-1:0]          st_thr;
  logic [NTHR-1:0][WIN-1:0] st_rdy, st_mem, st_grant;
  logic [NTHR:0][SCW-1:0]   slots_c;
  logic [NTHR:0][ACW-1:0]   alus_c;
  logic [NTHR:0]            lsu_c;

  // eligibility: ready and not stalled
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      elig[t]     = rdy_i[t] & {WIN{~stall_i[t]}};
      any_elig[t] = |elig[t];
    end
    both_elig = &any_elig;
  end

  smt_first_sel #(.WIN(WIN)) u_first (
    .policy_eq (policy_i == POL_EQUAL),
    .prio      (prio_q),
    .elig      (elig),
    .first     (first)
  );

  assign st_thr     = {~first, first};
  assign slots_c[0] = '0;
  assign alus_c[0]  = '0;
  assign lsu_c[0]   = 1'b1;

  for (genvar s = 0; s < NTHR; s++) begin : g_stage
    assign st_rdy[s] = elig[st_thr[s]];
    assign st_mem[s] = mem_i[st_thr[s]];

    smt_thread_pick #(
      .WIN(WIN), .ISSUE_W(ISSUE_W), .N_ALU(N_ALU)
    ) u_pick (
      .rdy          (st_rdy[s]),
      .mem          (st_mem[s]),
      .slots_in     (slots_c[s]),
      .alus_in      (alus_c[s]),
      .lsu_free_in  (lsu_c[s]),
      .grant        (st_grant[s]),
      .slots_out    (slots_c[s+1]),
      .alus_out     (alus_c[s+1]),
      .lsu_free_out (lsu_c[s+1])
    );
  end

  // stage grants back to thread order
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      grant_o[t] = (st_thr[0] == t[0]) ? st_grant[0] : st_grant[1];
    end
  end

  smt_slot_pack #(
    .WIN(WIN), .ISSUE_W(ISSUE_W), .N_ALU(N_ALU)
  ) u_pack (
    .st_grant  (st_grant),
    .st_mem    (st_mem),
    .first     (first),
    .slot_vld  (slot_vld_o),
    .slot_thr  (slot_thr_o),
    .slot_idx  (slot_idx_o),
    .slot_unit (slot_unit_o)
  );

  // priority pointer
  assign prio_en = both_elig;
  assign prio_d  = ~prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prio_q <= 1'b0;
    else if (prio_en) prio_q <= prio_d;
  end

  // issued counters
  for (genvar t = 0; t < NTHR; t++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    assign cnt_en = |grant_o[t];
    assign cnt_d  = cnt_q + CNT_W'($countones(grant_o[t]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign issued_cnt_o[t] = cnt_q;
  end
endmodule

// File: rtl/smt_issue_sel_chk.sv
module smt_issue_sel_chk #(
  parameter int WIN     = 4,
  parameter int ISSUE_W = 4,
  parameter int N_ALU   = 4,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int UNIT_W = $clog2(N_ALU + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          policy_i,
  input logic [1:0]                    stall_i,
  input logic [1:0][WIN-1:0]           rdy_i,
  input logic [1:0][WIN-1:0]           mem_i,
  input logic [1:0][WIN-1:0]           grant_o,
  input logic [ISSUE_W-1:0]            slot_vld_o,
  input logic [ISSUE_W-1:0]            slot_thr_o,
  input logic [ISSUE_W-1:0][IDX_W-1:0] slot_idx_o,
  input logic [ISSUE_W-1:0][UNIT_W-1:0] slot_unit_o,
  input logic [1:0][CNT_W-1:0]         issued_cnt_o,
  input logic                          prio_i
);
  logic [1:0][WIN-1:0] el;
  int   tot, n_mem, n_alu, n_el0, n_el1;
  logic left_alu, age_bad, both;

  always_comb begin
    el[0]    = rdy_i[0] & {WIN{~stall_i[0]}};
    el[1]    = rdy_i[1] & {WIN{~stall_i[1]}};
    both     = (|el[0]) && (|el[1]);
    n_el0    = $countones(el[0]);
    n_el1    = $countones(el[1]);
    tot      = $countones(grant_o);
    n_mem    = $countones(grant_o & mem_i);
    n_alu    = tot - n_mem;
    left_alu = |(el & ~grant_o & ~mem_i);
    age_bad  = 1'b0;
    for (int t = 0; t < 2; t++)
      for (int j = 0; j < WIN; j++)
        for (int i = 0; i < j; i++)
          if (grant_o[t][j] && el[t][i] && !grant_o[t][i] &&
              (mem_i[t][i] == mem_i[t][j] || !mem_i[t][i]))
            age_bad = 1'b1;
  end

  p_width_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tot <= ISSUE_W);
  p_stall_mute_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o[0] & {WIN{stall_i[0]}}) == '0 && (grant_o[1] & {WIN{stall_i[1]}}) == '0);
  p_fill_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot < ISSUE_W && n_alu < N_ALU) |-> !left_alu);
  p_one_lsu_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_mem <= 1);
  p_age_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !age_bad);
  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both |=> prio_i != $past(prio_i));
  p_ptr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both |=> prio_i == $past(prio_i));
  p_eq_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i && both) |-> (slot_vld_o[0] && slot_thr_o[0] == prio_i));
  p_thru_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!policy_i && n_el0 != n_el1 && both) |-> (slot_thr_o[0] == (n_el1 > n_el0)));
  p_pack_dense_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((slot_vld_o + 1'b1) & slot_vld_o) == '0) && ($countones(slot_vld_o) == tot));

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    p_unit_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[s] |-> ((slot_unit_o[s] == UNIT_W'(N_ALU)) ==
                          mem_i[slot_thr_o[s]][slot_idx_o[s]]));
  end

  for (genvar t = 0; t < 2; t++) begin : g_cnt
    p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> issued_cnt_o[t] ==
        $past(issued_cnt_o[t]) + CNT_W'($countones($past(grant_o[t]))));
  end
endmodule

bind smt_issue_sel smt_issue_sel_chk #(
  .WIN(WIN), .ISSUE_W(ISSUE_W), .N_ALU(N_ALU), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .policy_i     (policy_i),
  .stall_i      (stall_i),
  .rdy_i        (rdy_i),
  .mem_i        (mem_i),
  .grant_o      (grant_o),
  .slot_vld_o   (slot_vld_o),
  .slot_thr_o   (slot_thr_o),
  .slot_idx_o   (slot_idx_o),
  .slot_unit_o  (slot_unit_o),
  .issued_cnt_o (issued_cnt_o),
  .prio_i       (prio_q)
);

// File: tb/test_smt_issue_sel.sv
module test_smt_issue_sel;
  localparam int WIN = 4, ISSUE_W = 4, N_ALU = 4, CNT_W = 32;
  localparam int IDX_W = 2, UNIT_W = 3;

  logic                          clk_i = 1'b0;
  logic                          rst_ni;
  logic                          policy_i;
  logic [1:0]                    stall_i;
  logic [1:0][WIN-1:0]           rdy_i, mem_i, grant_o;
  logic [ISSUE_W-1:0]            slot_vld_o, slot_thr_o;
  logic [ISSUE_W-1:0][IDX_W-1:0] slot_idx_o;
  logic [ISSUE_W-1:0][UNIT_W-1:0] slot_unit_o;
  logic [1:0][CNT_W-1:0]         issued_cnt_o;

  int checks = 0, errors = 0;
  int exp_cnt0 = 0, exp_cnt1 = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  smt_issue_sel #(.WIN(WIN), .ISSUE_W(ISSUE_W), .N_ALU(N_ALU), .CNT_W(CNT_W))
  i_smt_issue_sel (.*);

  // {exp_first, policy, stall{t1,t0}, rdy0, mem0, rdy1, mem1, g0, g1}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'b00, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b0000},
    {1'b1, 1'b1, 2'b00, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1111},
    {1'b1, 1'b1, 2'b01, 4'b1111, 4'b0000, 4'b0011, 4'b0000, 4'b0000, 4'b0011},
    {1'b0, 1'b1, 2'b00, 4'b0011, 4'b0001, 4'b0111, 4'b0001, 4'b0011, 4'b0110},
    {1'b1, 1'b1, 2'b00, 4'b0011, 4'b0001, 4'b0111, 4'b0001, 4'b0010, 4'b0111},
    {1'b1, 1'b0, 2'b00, 4'b0001, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1111},
    {1'b1, 1'b0, 2'b00, 4'b0111, 4'b0000, 4'b0111, 4'b0000, 4'b0001, 4'b0111},
    {1'b0, 1'b0, 2'b00, 4'b0111, 4'b0000, 4'b0111, 4'b0000, 4'b0111, 4'b0001},
    {1'b0, 1'b0, 2'b10, 4'b1111, 4'b1100, 4'b1111, 4'b0000, 4'b0111, 4'b0000},
    {1'b0, 1'b1, 2'b11, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000},
    {1'b1, 1'b1, 2'b00, 4'b0000, 4'b0000, 4'b1001, 4'b1000, 4'b0000, 4'b1001},
    {1'b1, 1'b0, 2'b00, 4'b1000, 4'b1000, 4'b1100, 4'b1100, 4'b0000, 4'b0100}
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic pol, input logic [1:0] st,
                       input logic [3:0] r0, input logic [3:0] m0,
                       input logic [3:0] r1, input logic [3:0] m1);
    policy_i = pol; stall_i = st;
    rdy_i = {r1, r0}; mem_i = {m1, m0};
  endtask

  task automatic chk_slot(input int s, input logic thr, input logic [1:0] idx,
                          input logic [2:0] unit, input string req);
    chk(slot_vld_o[s] && slot_thr_o[s] == thr && slot_idx_o[s] == idx &&
        slot_unit_o[s] == unit, req,
        {slot_vld_o[s], slot_thr_o[s], 2'b0, slot_idx_o[s], 1'b0, slot_unit_o[s]},
        {1'b1, thr, 2'b0, idx, 1'b0, unit});
  endtask

  task automatic chk_cnt(input string req);
    chk(issued_cnt_o[0] == exp_cnt0, {req, " counter t0"}, issued_cnt_o[0], exp_cnt0);
    chk(issued_cnt_o[1] == exp_cnt1, {req, " counter t1"}, issued_cnt_o[1], exp_cnt1);
  endtask

  task automatic tick_count();
    exp_cnt0 += $countones(grant_o[0]);
    exp_cnt1 += $countones(grant_o[1]);
  endtask

  initial begin
    rst_ni = 1'b0;
    drive(1'b0, 2'b00, 4'h0, 4'h0, 4'h0, 4'h0);
    #12;
    // R8 reset state
    chk_cnt("R8 reset");
    chk(slot_vld_o == '0 && grant_o == '0, "R1 idle no grant", {slot_vld_o, grant_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [27:0] e;
      e = VEC[v];
      @(negedge clk_i);
      chk_cnt("R8 accumulate");
      drive(e[26], e[25:24], e[23:20], e[19:16], e[15:12], e[11:8]);
      #1;
      // grants cover R1 width, R2 fill, R3 lsu, R4 age, R6 throughput order
      chk(grant_o[0] == e[7:4], $sformatf("vec %0d R2 R3 R4 grant t0", v), grant_o[0], e[7:4]);
      chk(grant_o[1] == e[3:0], $sformatf("vec %0d R1 R6 grant t1", v), grant_o[1], e[3:0]);
      if (e[7:0] != 8'h00)
        chk(slot_thr_o[0] == e[27], $sformatf("vec %0d R5 R6 first thread", v),
            slot_thr_o[0], e[27]);
      if (v == 3) begin
        chk_slot(0, 1'b0, 2'd0, 3'd4, "R7 slot0 lsu");
        chk_slot(1, 1'b0, 2'd1, 3'd0, "R7 slot1");
        chk_slot(2, 1'b1, 2'd1, 3'd1, "R7 slot2");
        chk_slot(3, 1'b1, 2'd2, 3'd2, "R7 slot3");
      end
      tick_count();
    end

    // R3: memory entry 1 loses the unit, younger arithmetic entries still go
    @(negedge clk_i);
    chk_cnt("R8 accumulate");
    drive(1'b1, 2'b10, 4'b1111, 4'b0011, 4'b1111, 4'b0000);
    #1;
    chk(grant_o[0] == 4'b1101, "R3 blocked mem skip", grant_o[0], 4'b1101);
    chk_slot(0, 1'b0, 2'd0, 3'd4, "R7 lsu unit");
    chk_slot(1, 1'b0, 2'd2, 3'd0, "R7 alu0");
    chk_slot(2, 1'b0, 2'd3, 3'd1, "R7 alu1");
    chk(slot_vld_o[3] == 1'b0, "R7 slot3 empty", slot_vld_o[3], 0);
    tick_count();
    // R3 retry of the memory entry that stayed ready
    @(negedge clk_i);
    drive(1'b1, 2'b10, 4'b0010, 4'b0010, 4'b1111, 4'b0000);
    #1;
    chk(grant_o[0] == 4'b0010, "R3 retry granted", grant_o[0], 4'b0010);
    chk_slot(0, 1'b0, 2'd1, 3'd4, "R3 retry lsu");
    tick_count();

    // pointer to 1, then asynchronous reset must restore it and counters
    @(negedge clk_i);
    chk_cnt("R8 accumulate");
    drive(1'b1, 2'b00, 4'b1111, 4'b0000, 4'b1111, 4'b0000);
    #1;
    chk(slot_thr_o[0] == 1'b0, "R5 pointer at 0", slot_thr_o[0], 0);
    @(negedge clk_i);
    #1;
    chk(slot_thr_o[0] == 1'b1, "R5 pointer flipped", slot_thr_o[0], 1);
    rst_ni = 1'b0;
    #0.5;
    exp_cnt0 = 0; exp_cnt1 = 0;
    chk_cnt("R8 async reset");
    chk(slot_thr_o[0] == 1'b0, "R5 pointer reset", slot_thr_o[0], 0);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk(grant_o[0] == 4'b1111 && grant_o[1] == 4'b0000, "R5 after reset t0 first",
        grant_o, 8'h0F);
    @(negedge clk_i);
    chk(issued_cnt_o[0] == 32'd4, "R8 count after reset", issued_cnt_o[0], 4);
    checks++;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule